// File: doc/BRIEF.md
# Per-Cycle-Type Wait State Inserter

This block stretches selected processor machine cycles by exactly one clock. It watches the processor's memory request, refresh, I/O request, opcode-fetch, read and write strobes, together with an on-board ROM select. It detects the first clock of every new memory or I/O cycle. When the type of that cycle is one whose wait is enabled, it pulls the active-low wait line to the processor low for one clock period.

There are five enable bits, one for each cycle class: opcode fetch, any memory cycle, on-board ROM, input and output. An external ready line, when pulled low, forces wait through the same path. A registered wait-acknowledge output marks the clock in which the processor actually sits in the wait state. It is never a plain copy of the request.

The block runs on the processor clock. It is used between the processor's control pins and its wait input.

Top module: `wst_wait_inserter`

## Requirements
- R1: While reset is held, and in the first clock after release, `wait_n` is 1 and `wait_ack` is 0 as long as `ext_ready` is 1.
- R2: A new cycle starts when `(mem_req AND NOT refresh) OR io_req` rises. A memory request during refresh with no I/O request starts no cycle and inserts no wait.
- R3: An enabled cycle receives exactly one wait clock, the second clock of the cycle, counted from the clock in which the start condition first appears. Holding the start condition longer inserts no further wait.
- R4: Enable bit 0 (opcode fetch) inserts a wait only when `fetch` and `mem_req` are both 1.
- R5: Enable bit 1 (memory) inserts a wait for any cycle with `mem_req` 1.
- R6: Enable bit 2 (on-board ROM) inserts a wait when `rom_sel` is 1.
- R7: Enable bit 3 (input) inserts a wait when `io_req` and `rd_strobe` are both 1. It inserts none for an I/O write.
- R8: Enable bit 4 (output) inserts a wait when `io_req` and `wr_strobe` are both 1.
- R9: With all enable bits 0 and `ext_ready` 1, `wait_n` stays 1 for every cycle type.
- R10: `ext_ready` at 0 drives `wait_n` to 0 in the same clock, for as many clocks as it is held.
- R11: `wait_ack` is 1 in the clock after a clock in which `wait_n` was 0, and 0 otherwise. A request seen early in the cycle never shows on it in the same clock.
- R12: Enable bits are registered. A value presented in one clock governs the start pulse of the following clock, and all bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | input | 1 | Memory request, active high |
| refresh | input | 1 | Refresh cycle marker, active high |
| io_req | input | 1 | I/O request, active high |
| fetch | input | 1 | Opcode-fetch marker, active high |
| rd_strobe | input | 1 | Read strobe, active high |
| wr_strobe | input | 1 | Write strobe, active high |
| rom_sel | input | 1 | On-board ROM selected, active high |
| ext_ready | input | 1 | External ready; 0 forces a wait |
| wait_en_cfg | input | 5 | Enables: bit0 fetch, bit1 memory, bit2 ROM, bit3 input, bit4 output |
| wait_n | output | 1 | Active-low wait request to the processor |
| wait_ack | output | 1 | High during an inserted wait clock |

## Verification
The bench builds the block with its default parameters: five classes and a two-stage start detector. With these settings the wait lands on the second clock of each cycle, and the bench's scoreboard predicts that clock directly. The scoreboard also drives cycles held for several clocks, back-to-back cycles with a single idle clock between them, and enable changes in the clock just before or just at the start pulse. These cases cover the single-pulse guarantee and the one-clock configuration latency.

// File: rtl/wst_pkg.sv
package wst_pkg;
  localparam int N_CLASS = 5;

  typedef enum int {
    CLS_FETCH = 0,
    CLS_MEM   = 1,
    CLS_ROM   = 2,
    CLS_IN    = 3,
    CLS_OUT   = 4
  } wst_class_e;

  // A memory cycle that is not refresh, or any I/O cycle, begins a machine cycle.
  function automatic logic cycle_start_f(input logic mreq, input logic rfsh,
                                         input logic iorq);
    return (mreq & ~rfsh) | iorq;
  endfunction

  // Classify the current cycle into one bit per class.
  function automatic logic [N_CLASS-1:0] class_vec_f(
      input logic mreq, input logic m1, input logic rom,
      input logic iorq, input logic rd, input logic wr);
    logic [N_CLASS-1:0] v;
    v = '0;
    v[CLS_FETCH] = m1 & mreq;
    v[CLS_MEM]   = mreq;
    v[CLS_ROM]   = rom;
    v[CLS_IN]    = iorq & rd;
    v[CLS_OUT]   = iorq & wr;
    return v;
  endfunction
endpackage

// File: rtl/wst_start_edge.sv
module wst_start_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_lvl,
  output logic start_pulse
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= start_lvl;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign start_pulse = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/wst_cfg_reg.sv
module wst_cfg_reg #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cfg_in,
  output logic [WIDTH-1:0] cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_in;
  end
endmodule

// File: rtl/wst_class_gate.sv
module wst_class_gate #(
  parameter int N = 5
) (
  input  logic [N-1:0] cls,
  input  logic [N-1:0] en,
  output logic         hit
);
  logic [N-1:0] per_class;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cls
      assign per_class[g] = cls[g] & en[g];
    end
  endgenerate

  assign hit = |per_class;
endmodule

// File: rtl/wst_wait_inserter.sv
module wst_wait_inserter
  import wst_pkg::*;
#(
  parameter int NCLS   = N_CLASS,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_req,
  input  logic            refresh,
  input  logic            io_req,
  input  logic            fetch,
  input  logic            rd_strobe,
  input  logic            wr_strobe,
  input  logic            rom_sel,
  input  logic            ext_ready,
  input  logic [NCLS-1:0] wait_en_cfg,
  output logic            wait_n,
  output logic            wait_ack
);
  logic            cycle_start;
  logic            start_pulse;
  logic [NCLS-1:0] cfg_q;
  logic [NCLS-1:0] cls_vec;
  logic            class_hit;
  logic            wait_req;
  logic            ack_q;

  assign cycle_start = cycle_start_f(mem_req, refresh, io_req);
  assign cls_vec     = NCLS'(class_vec_f(mem_req, fetch, rom_sel,
                                         io_req, rd_strobe, wr_strobe));

  wst_start_edge #(.STAGES(STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_lvl  (cycle_start),
    .start_pulse(start_pulse)
  );

  wst_cfg_reg #(.WIDTH(NCLS)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg_in(wait_en_cfg),
    .cfg_q (cfg_q)
  );

  wst_class_gate #(.N(NCLS)) u_gate (
    .cls(cls_vec),
    .en (cfg_q),
    .hit(class_hit)
  );

  assign wait_req = (start_pulse & class_hit) | ~ext_ready;
  assign wait_n   = ~wait_req;

  // The processor samples the wait line at the clock edge; the clock that
  // follows is the wait state itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= wait_req;
  end

  assign wait_ack = ack_q;
endmodule

// File: rtl/wst_wait_inserter_chk.sv
module wst_wait_inserter_chk #(
  parameter int NCLS = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            refresh,
  input logic            io_req,
  input logic            ext_ready,
  input logic [NCLS-1:0] cfg_q,
  input logic            cycle_start,
  input logic            start_pulse,
  input logic            wait_n,
  input logic            wait_ack
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R3

  AST_REFRESH_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && refresh && !io_req) |-> !cycle_start); // R2

  AST_ACK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |=> wait_ack); // R11

  AST_ACK_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    wait_n |=> !wait_ack); // R11

  AST_READY_FORCES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ready |-> !wait_n); // R10

  AST_DISABLED_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == '0 && ext_ready) |-> wait_n); // R9
endmodule

bind wst_wait_inserter wst_wait_inserter_chk #(.NCLS(NCLS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .refresh    (refresh),
  .io_req     (io_req),
  .ext_ready  (ext_ready),
  .cfg_q      (cfg_q),
  .cycle_start(cycle_start),
  .start_pulse(start_pulse),
  .wait_n     (wait_n),
  .wait_ack   (wait_ack)
);

// File: tb/tb_wst_wait_inserter.sv
`timescale 1ns/1ps
module tb_wst_wait_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_req = 0, refresh = 0, io_req = 0, fetch = 0;
  logic       rd_strobe = 0, wr_strobe = 0, rom_sel = 0, ext_ready = 1;
  logic [4:0] wait_en_cfg = '0;
  logic       wait_n, wait_ack;

  always #2 clk = ~clk; // 250 MHz

  wst_wait_inserter dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .refresh(refresh),
    .io_req(io_req), .fetch(fetch), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .rom_sel(rom_sel), .ext_ready(ext_ready),
    .wait_en_cfg(wait_en_cfg), .wait_n(wait_n), .wait_ack(wait_ack)
  );

  typedef struct {
    string tag;
    logic  exp_wait_n;
    logic  exp_ack;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench-side history of the requirement model.
  logic h_start1 = 0, h_start2 = 0, h_req_prev = 0;
  logic [4:0] h_cfg_prev = '0;

  task automatic check(string tag, logic act, logic exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus; pushes the expected outputs for that clock.
  task automatic step(string tag, logic mr, logic rf, logic io, logic m1,
                      logic rd, logic wr, logic rom, logic rdy, logic [4:0] cfg);
    item_t it;
    logic start_now, pulse, hit, req;
    logic [4:0] cls;
    @(negedge clk);
    mem_req = mr; refresh = rf; io_req = io; fetch = m1;
    rd_strobe = rd; wr_strobe = wr; rom_sel = rom; ext_ready = rdy;
    wait_en_cfg = cfg;
    start_now = (mr && !rf) || io;                 // R2
    pulse     = h_start1 && !h_start2;             // R3: second clock of the cycle
    cls = {io && wr, io && rd, rom, mr, m1 && mr}; // R4..R8 bit order
    hit = (cls & h_cfg_prev) != 5'b0;              // R12: previous clock's enables
    req = (pulse && hit) || !rdy;                  // R10
    it.tag = tag;
    it.exp_wait_n = !req;
    it.exp_ack = h_req_prev;                       // R11
    q.push_back(it);
    h_start2 = h_start1; h_start1 = start_now;
    h_req_prev = req; h_cfg_prev = cfg;
  endtask

  task automatic idle(string tag, logic [4:0] cfg, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0, 1, cfg);
  endtask

  task automatic mem_cyc(string tag, logic [4:0] cfg, logic m1, logic rd,
                         logic rom, logic rf, int len);
    for (int i = 0; i < len; i++) step(tag, 1, rf, 0, m1, rd, !rd, rom, 1, cfg);
  endtask

  task automatic io_cyc(string tag, logic [4:0] cfg, logic rd, int len);
    for (int i = 0; i < len; i++) step(tag, 0, 0, 1, 0, rd, !rd, 0, 1, cfg);
  endtask

  // Monitor: compare mid-clock, 1 ns before the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.tag, wait_n, it.exp_wait_n, "wait_n");
        check(it.tag, wait_ack, it.exp_ack, "wait_ack");
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    #1;
    check("R1", wait_n, 1'b1, "wait_n in reset");
    check("R1", wait_ack, 1'b0, "wait_ack in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 5'b0, 2);

    // R9: nothing enabled
    mem_cyc("R9", 5'b00000, 1, 1, 1, 0, 3);
    io_cyc("R9", 5'b00000, 0, 3);
    idle("R9", 5'b00000, 2);

    // R4: fetch enable, fetch vs plain read
    idle("R4", 5'b00001, 1);
    mem_cyc("R4", 5'b00001, 1, 1, 0, 0, 3);
    idle("R4", 5'b00001, 1);
    mem_cyc("R4", 5'b00001, 0, 1, 0, 0, 3);
    idle("R4", 5'b00001, 1);

    // R5 and R2: memory enable, normal vs refresh-only
    idle("R5", 5'b00010, 1);
    mem_cyc("R5", 5'b00010, 0, 0, 0, 0, 3);
    idle("R2", 5'b00010, 1);
    mem_cyc("R2", 5'b00010, 0, 1, 0, 1, 3);
    idle("R2", 5'b00010, 1);

    // R6: ROM enable
    idle("R6", 5'b00100, 1);
    mem_cyc("R6", 5'b00100, 0, 1, 0, 0, 3);
    idle("R6", 5'b00100, 1);
    mem_cyc("R6", 5'b00100, 0, 1, 1, 0, 3);
    idle("R6", 5'b00100, 1);

    // R7 and R8: input and output enables
    idle("R7", 5'b01000, 1);
    io_cyc("R7", 5'b01000, 1, 3);
    idle("R7", 5'b01000, 1);
    io_cyc("R7", 5'b01000, 0, 3);
    idle("R8", 5'b10000, 1);
    io_cyc("R8", 5'b10000, 0, 3);
    idle("R8", 5'b10000, 1);
    io_cyc("R8", 5'b10000, 1, 3);
    idle("R8", 5'b10000, 1);

    // R3: long cycle gets one wait; back-to-back cycles each get one
    idle("R3", 5'b11111, 1);
    io_cyc("R3", 5'b11111, 1, 8);
    idle("R3", 5'b11111, 1);
    mem_cyc("R3", 5'b11111, 1, 1, 0, 0, 2);
    idle("R3", 5'b11111, 1);
    mem_cyc("R3", 5'b11111, 0, 0, 0, 0, 2);
    idle("R3", 5'b00000, 2);

    // R12: enable presented with the start clock applies; at the pulse clock it does not
    mem_cyc("R12", 5'b00010, 0, 1, 0, 0, 1);
    mem_cyc("R12", 5'b00000, 0, 1, 0, 0, 2);
    idle("R12", 5'b00000, 2);
    mem_cyc("R12", 5'b00000, 0, 1, 0, 0, 1);
    mem_cyc("R12", 5'b00010, 0, 1, 0, 0, 2);
    idle("R12", 5'b00000, 2);

    // R10 and R11: external ready held low, then released
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 5'b0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 5'b0);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 1, 5'b0);
    idle("R11", 5'b0, 2);

    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule